// File: doc/BRIEF.md
# CPU Power Zone Sequencer

This block controls the power zone of a single processor core. It drives the zone's memory power, logic power, clock enable, isolation and reset-release outputs in a fixed order. Before it takes a step that depends on the power switches, it waits for the acknowledge from the memory power switch or from the digital power gate. A power-up sequence turns the zone on and lets the core run. A power-down sequence undoes the same steps in mirror order and finally sets the core's halt output.

A sequence can be started by a one-cycle pulse on a request pin or by a software write with a command bit set. Software reads a status word. It shows the control outputs, manual mode, the busy flag, a sticky timeout error, the current state code and the two acknowledge inputs. Each acknowledge wait is bounded by a cycle counter. The counter's length comes from the clock frequency and a timeout in milliseconds. If an acknowledge never arrives, the sequencer sets the error, returns to idle and leaves the outputs where they were.

States: `S_IDLE`; power-up `S_UP_ISO` → `S_UP_MANUAL` → `S_UP_LOGIC` → `S_UP_MEM` → `S_UP_WAIT_MEM` → `S_UP_CLK` → `S_UP_WAIT_LOGIC` → `S_UP_UNISO` → `S_UP_RELEASE` → `S_IDLE`; power-down `S_DN_MANUAL` → `S_DN_RESET` → `S_DN_CLKOFF` → `S_DN_ISO` → `S_DN_MEMOFF` → `S_DN_WAIT_MEM` → `S_DN_LOGICOFF` → `S_DN_WAIT_LOGIC` → `S_DN_HALT` → `S_IDLE`. Each wait state moves on when its acknowledge condition holds. It returns to `S_IDLE` when the timer expires.

Top module: `pzs_power_zone`

## Requirements
- R1: After reset:
  - isolation, halt and the off flag are set;
  - memory power, logic power, clock enable, reset release, manual mode, busy and the error are clear;
  - the status word therefore reads 0x8000_0040 while both acknowledges are low.
- R2: Power-up performs these steps one per cycle: isolation on, manual mode on, logic power on, memory power on. It then waits for mem_ack to be 1 before the clock is enabled. The clock enable is never high unless memory power and logic power are both on.
- R3: After the clock is enabled, power-up waits for logic_ack to be 1. It then releases isolation, and in a later cycle sets reset release and clears halt. Reset release is never high while isolation or halt is set, or while the clock is off.
- R4: Power-down performs these steps one per cycle: manual mode on, reset release cleared, clock off, isolation on, memory power off. It then waits for mem_ack to be 0.
- R5: Power-down then turns logic power off, waits for logic_ack to be 0, and sets halt. Halt never rises while memory power or logic power is on.
- R6: A power-down request while core_index is 0 is refused and leaves every output unchanged.
- R7: A power-up request is accepted only when the off flag (status bit 31, the inverse of reset release) is 1. Otherwise it is ignored.
- R8: While a sequence is running, busy (status bit 3) is 1 and all new requests are ignored.
- R9: Each acknowledge wait lasts at most TMO_CYC = CLK_KHZ*TMO_MS cycles. When the wait expires:
  - the sticky error (status bit 2) is set;
  - the sequencer returns to idle;
  - the outputs keep the values they had.
  A power-up whose memory acknowledge never comes is busy for exactly 4 + TMO_CYC cycles.
- R10: A write with sw_wr high starts power-up when data bit 10 is set and power-down when data bit 9 is set. Data bit 2 clears the error. Clearing the error changes no control output.
- R11: Status word layout:
  - bit 0 clock enable, bit 1 reset release, bit 2 error, bit 3 busy;
  - bit 4 memory power, bit 5 logic power, bit 6 isolation, bit 7 manual mode;
  - bits 15:11 state code (idle = 0);
  - bit 28 logic_ack, bit 29 mem_ack, bit 31 off flag;
  - all other bits are 0.
- R12: When power-up and power-down are requested in the same idle cycle, power-up takes precedence if it is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_index | input | CORE_W | Index of the core this zone serves |
| up_req | input | 1 | Power-up request pulse |
| dn_req | input | 1 | Power-down request pulse |
| sw_wr | input | 1 | Software command write strobe |
| sw_wdata | input | 32 | Software command data (bits 10, 9, 2 used) |
| mem_ack | input | 1 | Memory power switch acknowledge |
| logic_ack | input | 1 | Digital power gate acknowledge |
| mem_pwr_en | output | 1 | Memory power enable |
| logic_pwr_en | output | 1 | Logic power enable |
| clk_en | output | 1 | Core clock enable |
| iso_en | output | 1 | Output isolation enable |
| rst_rel | output | 1 | Reset release (1 = core out of reset) |
| halt | output | 1 | Core halt |
| busy | output | 1 | A sequence is running |
| timeout_err | output | 1 | Sticky acknowledge timeout |
| status | output | 32 | Status word |

## Verification
The bench goes after these corner cases:
- **Core 0 power-down.** A design that ignored the core index would take core 0 down.
- **Power-up while already on.** A design that ignored the off flag would restart a running core through isolation.
- **Requests during a busy sequence.** A design that accepted them would end in the wrong power state.
- **Timeouts in both directions.** The busy length is measured exactly. A miscounted timer, or an error that is not sticky, shows up as a wrong cycle count or a cleared flag.
- **Clearing the error.** The bench confirms that the clear leaves the partially sequenced outputs untouched.
- **Simultaneous up and down requests.** A design that gave power-down precedence would leave the zone off.

// File: rtl/pzs_pkg.sv
package pzs_pkg;

    typedef enum logic [4:0] {
        S_IDLE          = 5'd0,
        S_UP_ISO        = 5'd1,
        S_UP_MANUAL     = 5'd2,
        S_UP_LOGIC      = 5'd3,
        S_UP_MEM        = 5'd4,
        S_UP_WAIT_MEM   = 5'd5,
        S_UP_CLK        = 5'd6,
        S_UP_WAIT_LOGIC = 5'd7,
        S_UP_UNISO      = 5'd8,
        S_UP_RELEASE    = 5'd9,
        S_DN_MANUAL     = 5'd10,
        S_DN_RESET      = 5'd11,
        S_DN_CLKOFF     = 5'd12,
        S_DN_ISO        = 5'd13,
        S_DN_MEMOFF     = 5'd14,
        S_DN_WAIT_MEM   = 5'd15,
        S_DN_LOGICOFF   = 5'd16,
        S_DN_WAIT_LOGIC = 5'd17,
        S_DN_HALT       = 5'd18
    } pzs_state_e;

    typedef struct packed {
        logic manual;
        logic iso;
        logic logic_en;
        logic mem_en;
        logic rst_rel;
        logic clk_en;
    } pzs_ctrl_t;

    // status word bit positions
    localparam int unsigned SB_CLK       = 0;
    localparam int unsigned SB_RST       = 1;
    localparam int unsigned SB_ERR       = 2;
    localparam int unsigned SB_BUSY      = 3;
    localparam int unsigned SB_MEM       = 4;
    localparam int unsigned SB_LOGIC     = 5;
    localparam int unsigned SB_ISO       = 6;
    localparam int unsigned SB_MANUAL    = 7;
    localparam int unsigned SB_STATE_LO  = 11;
    localparam int unsigned SB_LOGIC_ACK = 28;
    localparam int unsigned SB_MEM_ACK   = 29;
    localparam int unsigned SB_OFF       = 31;

    // software command bit positions
    localparam int unsigned CB_UP     = 10;
    localparam int unsigned CB_DN     = 9;
    localparam int unsigned CB_ERRCLR = 2;

    function automatic logic is_up_state(pzs_state_e s);
        return (s >= S_UP_ISO) && (s <= S_UP_RELEASE);
    endfunction

    function automatic logic is_wait_state(pzs_state_e s);
        return (s == S_UP_WAIT_MEM) || (s == S_UP_WAIT_LOGIC) ||
               (s == S_DN_WAIT_MEM) || (s == S_DN_WAIT_LOGIC);
    endfunction

endpackage

// File: rtl/pzs_ack_timer.sv
module pzs_ack_timer #(
    parameter int unsigned TMO_CYC = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack_ok,
    output logic expired
);
    localparam int unsigned CW  = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    assign expired = run && !ack_ok && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || ack_ok || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pzs_fsm.sv
module pzs_fsm
    import pzs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_cmd,
    input  logic       dn_cmd,
    input  logic       core_is_zero,
    input  logic       core_off,
    input  logic       mem_ack,
    input  logic       logic_ack,
    input  logic       expired,
    output pzs_state_e st,
    output logic       wait_run,
    output logic       ack_ok
);
    pzs_state_e nxt;

    assign wait_run = is_wait_state(st);

    // acknowledge condition for the current wait state
    always_comb begin
        unique case (st)
            S_UP_WAIT_MEM:   ack_ok = mem_ack;
            S_UP_WAIT_LOGIC: ack_ok = logic_ack;
            S_DN_WAIT_MEM:   ack_ok = !mem_ack;
            S_DN_WAIT_LOGIC: ack_ok = !logic_ack;
            default:         ack_ok = 1'b0;
        endcase
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: begin
                if (up_cmd && core_off)
                    nxt = S_UP_ISO;
                else if (dn_cmd && !core_is_zero)
                    nxt = S_DN_MANUAL;
            end
            S_UP_ISO:        nxt = S_UP_MANUAL;
            S_UP_MANUAL:     nxt = S_UP_LOGIC;
            S_UP_LOGIC:      nxt = S_UP_MEM;
            S_UP_MEM:        nxt = S_UP_WAIT_MEM;
            S_UP_WAIT_MEM: begin
                if (ack_ok)       nxt = S_UP_CLK;
                else if (expired) nxt = S_IDLE;
            end
            S_UP_CLK:        nxt = S_UP_WAIT_LOGIC;
            S_UP_WAIT_LOGIC: begin
                if (ack_ok)       nxt = S_UP_UNISO;
                else if (expired) nxt = S_IDLE;
            end
            S_UP_UNISO:      nxt = S_UP_RELEASE;
            S_UP_RELEASE:    nxt = S_IDLE;
            S_DN_MANUAL:     nxt = S_DN_RESET;
            S_DN_RESET:      nxt = S_DN_CLKOFF;
            S_DN_CLKOFF:     nxt = S_DN_ISO;
            S_DN_ISO:        nxt = S_DN_MEMOFF;
            S_DN_MEMOFF:     nxt = S_DN_WAIT_MEM;
            S_DN_WAIT_MEM: begin
                if (ack_ok)       nxt = S_DN_LOGICOFF;
                else if (expired) nxt = S_IDLE;
            end
            S_DN_LOGICOFF:   nxt = S_DN_WAIT_LOGIC;
            S_DN_WAIT_LOGIC: begin
                if (ack_ok)       nxt = S_DN_HALT;
                else if (expired) nxt = S_IDLE;
            end
            S_DN_HALT:       nxt = S_IDLE;
            default:         nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end
endmodule

// File: rtl/pzs_ctrl_regs.sv
module pzs_ctrl_regs
    import pzs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pzs_state_e st,
    input  logic       expired,
    input  logic       err_clr,
    output pzs_ctrl_t  ctrl,
    output logic       halt,
    output logic       err
);
    localparam pzs_ctrl_t CTRL_RST = '{manual: 1'b0, iso: 1'b1, logic_en: 1'b0,
                                       mem_en: 1'b0, rst_rel: 1'b0, clk_en: 1'b0};

    // each action state applies its step on the edge that leaves it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
            halt <= 1'b1;
        end else begin
            unique case (st)
                S_UP_ISO:      ctrl.iso      <= 1'b1;
                S_UP_MANUAL:   ctrl.manual   <= 1'b1;
                S_UP_LOGIC:    ctrl.logic_en <= 1'b1;
                S_UP_MEM:      ctrl.mem_en   <= 1'b1;
                S_UP_CLK:      ctrl.clk_en   <= 1'b1;
                S_UP_UNISO:    ctrl.iso      <= 1'b0;
                S_UP_RELEASE: begin
                    ctrl.rst_rel <= 1'b1;
                    halt         <= 1'b0;
                end
                S_DN_MANUAL:   ctrl.manual   <= 1'b1;
                S_DN_RESET:    ctrl.rst_rel  <= 1'b0;
                S_DN_CLKOFF:   ctrl.clk_en   <= 1'b0;
                S_DN_ISO:      ctrl.iso      <= 1'b1;
                S_DN_MEMOFF:   ctrl.mem_en   <= 1'b0;
                S_DN_LOGICOFF: ctrl.logic_en <= 1'b0;
                S_DN_HALT:     halt          <= 1'b1;
                default: ;
            endcase
        end
    end

    // sticky timeout flag; a new expiry wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (expired) err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end
endmodule

// File: rtl/pzs_status.sv
module pzs_status
    import pzs_pkg::*;
(
    input  pzs_ctrl_t   ctrl,
    input  pzs_state_e  st,
    input  logic        err,
    input  logic        busy,
    input  logic        mem_ack,
    input  logic        logic_ack,
    output logic [31:0] status
);
    always_comb begin
        status                       = '0;
        status[SB_CLK]               = ctrl.clk_en;
        status[SB_RST]               = ctrl.rst_rel;
        status[SB_ERR]               = err;
        status[SB_BUSY]              = busy;
        status[SB_MEM]               = ctrl.mem_en;
        status[SB_LOGIC]             = ctrl.logic_en;
        status[SB_ISO]               = ctrl.iso;
        status[SB_MANUAL]            = ctrl.manual;
        status[SB_STATE_LO +: 5]     = st;
        status[SB_LOGIC_ACK]         = logic_ack;
        status[SB_MEM_ACK]           = mem_ack;
        status[SB_OFF]               = !ctrl.rst_rel;
    end
endmodule

// File: rtl/pzs_power_zone.sv
module pzs_power_zone
    import pzs_pkg::*;
#(
    parameter int unsigned CORE_W  = 2,
    parameter int unsigned CLK_KHZ = 125_000,
    parameter int unsigned TMO_MS  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_index,
    input  logic              up_req,
    input  logic              dn_req,
    input  logic              sw_wr,
    input  logic [31:0]       sw_wdata,
    input  logic              mem_ack,
    input  logic              logic_ack,
    output logic              mem_pwr_en,
    output logic              logic_pwr_en,
    output logic              clk_en,
    output logic              iso_en,
    output logic              rst_rel,
    output logic              halt,
    output logic              busy,
    output logic              timeout_err,
    output logic [31:0]       status
);
    localparam int unsigned TMO_CYC = CLK_KHZ * TMO_MS;

    pzs_state_e st_q;
    pzs_ctrl_t  ctrl;
    logic       wait_run, ack_ok, expired;
    logic       up_cmd, dn_cmd, err_clr;
    logic       unused_wdata;

    assign up_cmd  = up_req | (sw_wr & sw_wdata[CB_UP]);
    assign dn_cmd  = dn_req | (sw_wr & sw_wdata[CB_DN]);
    assign err_clr = sw_wr & sw_wdata[CB_ERRCLR];
    assign unused_wdata = ^{sw_wdata[31:11], sw_wdata[8:3], sw_wdata[1:0]};

    pzs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_cmd       (up_cmd),
        .dn_cmd       (dn_cmd),
        .core_is_zero (core_index == '0),
        .core_off     (!ctrl.rst_rel),
        .mem_ack      (mem_ack),
        .logic_ack    (logic_ack),
        .expired      (expired),
        .st           (st_q),
        .wait_run     (wait_run),
        .ack_ok       (ack_ok)
    );

    pzs_ack_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .ack_ok  (ack_ok),
        .expired (expired)
    );

    pzs_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st_q),
        .expired (expired),
        .err_clr (err_clr),
        .ctrl    (ctrl),
        .halt    (halt),
        .err     (timeout_err)
    );

    assign busy = (st_q != S_IDLE);

    pzs_status u_status (
        .ctrl      (ctrl),
        .st        (st_q),
        .err       (timeout_err),
        .busy      (busy),
        .mem_ack   (mem_ack),
        .logic_ack (logic_ack),
        .status    (status)
    );

    assign mem_pwr_en   = ctrl.mem_en;
    assign logic_pwr_en = ctrl.logic_en;
    assign clk_en       = ctrl.clk_en;
    assign iso_en       = ctrl.iso;
    assign rst_rel      = ctrl.rst_rel;
endmodule

// File: rtl/pzs_power_zone_chk.sv
module pzs_power_zone_chk
    import pzs_pkg::*;
#(
    parameter int unsigned CORE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CORE_W-1:0] core_index,
    input logic              mem_pwr_en,
    input logic              logic_pwr_en,
    input logic              clk_en,
    input logic              iso_en,
    input logic              rst_rel,
    input logic              halt,
    input logic              busy,
    input logic              timeout_err,
    input pzs_state_e        st
);
    assert_clk_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (mem_pwr_en && logic_pwr_en));

    assert_release_after_iso_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rel |-> (!iso_en && clk_en && !halt));

    assert_halt_after_power_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> (!mem_pwr_en && !logic_pwr_en));

    assert_core0_stays_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_rel) |-> (core_index != '0));

    assert_running_core_no_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(rst_rel)) |-> (st == S_DN_MANUAL));

    assert_busy_no_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && is_up_state($past(st))) |-> is_up_state(st));

    assert_err_from_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (is_wait_state($past(st)) && st == S_IDLE));
endmodule

bind pzs_power_zone pzs_power_zone_chk #(.CORE_W(CORE_W)) u_pzs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_index   (core_index),
    .mem_pwr_en   (mem_pwr_en),
    .logic_pwr_en (logic_pwr_en),
    .clk_en       (clk_en),
    .iso_en       (iso_en),
    .rst_rel      (rst_rel),
    .halt         (halt),
    .busy         (busy),
    .timeout_err  (timeout_err),
    .st           (st_q)
);

// File: tb/pzs_power_zone_tb.sv
module pzs_power_zone_tb_top;
    localparam int unsigned CORE_W  = 2;
    localparam int unsigned CLK_KHZ = 1;
    localparam int unsigned TMO_MS  = 40;
    localparam int          TMO     = CLK_KHZ * TMO_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CORE_W-1:0] core_index = '0;
    logic up_req = 1'b0, dn_req = 1'b0, sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic mem_ack, logic_ack;
    logic mem_pwr_en, logic_pwr_en, clk_en, iso_en, rst_rel, halt, busy, timeout_err;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    int md_dly = 0, ld_dly = 0;
    int mcnt, lcnt;

    always #4 clk = ~clk;

    pzs_power_zone #(.CORE_W(CORE_W), .CLK_KHZ(CLK_KHZ), .TMO_MS(TMO_MS)) dut_i (
        .clk(clk), .rst_n(rst_n), .core_index(core_index), .up_req(up_req),
        .dn_req(dn_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .mem_ack(mem_ack),
        .logic_ack(logic_ack), .mem_pwr_en(mem_pwr_en), .logic_pwr_en(logic_pwr_en),
        .clk_en(clk_en), .iso_en(iso_en), .rst_rel(rst_rel), .halt(halt),
        .busy(busy), .timeout_err(timeout_err), .status(status)
    );

    // switch models: each ack follows its enable after a delay; 255 = never
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mcnt <= 0;
        end else if (mem_ack != mem_pwr_en) begin
            if (md_dly < 255 && mcnt >= md_dly) begin mem_ack <= mem_pwr_en; mcnt <= 0; end
            else mcnt <= mcnt + 1;
        end else mcnt <= 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            logic_ack <= 1'b0; lcnt <= 0;
        end else if (logic_ack != logic_pwr_en) begin
            if (ld_dly < 255 && lcnt >= ld_dly) begin logic_ack <= logic_pwr_en; lcnt <= 0; end
            else lcnt <= lcnt + 1;
        end else lcnt <= 0;
    end

    // {halt, manual, iso, logic, mem, rst_rel, clk}
    localparam logic [6:0] ON  = 7'b0_1_0_1_1_1_1;
    localparam logic [6:0] OFF = 7'b1_1_1_0_0_0_0;
    localparam logic [1:0] OP_HU = 2'd0, OP_HD = 2'd1, OP_SU = 2'd2, OP_SD = 2'd3;
    localparam logic [1:0] K_UP = 2'd0, K_DN = 2'd1, K_REF = 2'd2, K_IGN = 2'd3;

    // [29:28] kind [27:26] op [25:24] core [23:16] mem dly [15:8] logic dly [7:1] ctrl [0] err
    localparam logic [29:0] VEC [0:8] = '{
        {K_UP,  OP_HU, 2'd1, 8'd2, 8'd3, ON,  1'b0},
        {K_DN,  OP_HD, 2'd1, 8'd1, 8'd1, OFF, 1'b0},
        {K_UP,  OP_SU, 2'd2, 8'd5, 8'd0, ON,  1'b0},
        {K_DN,  OP_SD, 2'd2, 8'd0, 8'd4, OFF, 1'b0},
        {K_UP,  OP_HU, 2'd0, 8'd1, 8'd1, ON,  1'b0},
        {K_REF, OP_HD, 2'd0, 8'd1, 8'd1, ON,  1'b0},
        {K_REF, OP_SD, 2'd0, 8'd1, 8'd1, ON,  1'b0},
        {K_IGN, OP_HU, 2'd0, 8'd1, 8'd1, ON,  1'b0},
        {K_DN,  OP_HD, 2'd3, 8'd2, 8'd2, OFF, 1'b0}
    };

    function automatic logic [6:0] obs();
        return {halt, status[7], iso_en, logic_pwr_en, mem_pwr_en, rst_rel, clk_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [CORE_W-1:0] core);
        @(negedge clk);
        core_index = core;
        case (op)
            OP_HU: up_req = 1'b1;
            OP_HD: dn_req = 1'b1;
            OP_SU: begin sw_wr = 1'b1; sw_wdata = 32'h1 << 10; end
            default: begin sw_wr = 1'b1; sw_wdata = 32'h1 << 9; end
        endcase
        @(negedge clk);
        up_req = 1'b0; dn_req = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 status layout
        chk("R1 status", status, 32'h8000_0040);
        chk("R1 halt", {31'b0, halt}, 32'd1);

        for (int i = 0; i < 9; i++) begin
            md_dly = int'(VEC[i][23:16]);
            ld_dly = int'(VEC[i][15:8]);
            issue(VEC[i][27:26], VEC[i][25:24]);
            wait_idle(n);
            case (VEC[i][29:28])
                K_UP:    tag = "R2 R3 R10 power-up";
                K_DN:    tag = "R4 R5 R10 power-down";
                K_REF:   tag = "R6 core0 refuse";
                default: tag = "R7 up when on";
            endcase
            chk(tag, {25'b0, obs()}, {25'b0, VEC[i][7:1]});
            chk(tag, {31'b0, timeout_err}, {31'b0, VEC[i][0]});
        end

        // R9: power-up whose memory acknowledge never comes (zone is off)
        md_dly = 255;
        issue(OP_HU, 2'd1);
        wait_idle(n);
        chk("R9 busy length", n, 4 + TMO);
        chk("R9 err", {31'b0, timeout_err}, 32'd1);
        chk("R9 outputs kept", {25'b0, obs()}, {25'b0, 7'b1_1_1_1_1_0_0});
        chk("R11 status err", {28'b0, status[3:0]}, 32'h4);

        // R10: error clear by write of bit 2 leaves outputs alone
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = 32'h1 << 2;
        @(negedge clk);
        sw_wr = 1'b0; sw_wdata = '0;
        chk("R10 err clear", {31'b0, timeout_err}, 32'd0);
        chk("R10 outputs kept", {25'b0, obs()}, {25'b0, 7'b1_1_1_1_1_0_0});

        md_dly = 1;
        issue(OP_HU, 2'd1);
        wait_idle(n);
        chk("R2 retry on", {25'b0, obs()}, {25'b0, ON});
        chk("R11 status on", status, 32'h3000_00B3);

        // R9: power-down whose logic acknowledge never clears
        ld_dly = 255;
        issue(OP_HD, 2'd1);
        wait_idle(n);
        chk("R9 dn err", {31'b0, timeout_err}, 32'd1);
        chk("R9 dn outputs", {25'b0, obs()}, {25'b0, 7'b0_1_1_0_0_0_0});

        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = 32'h1 << 2;
        @(negedge clk);
        sw_wr = 1'b0; sw_wdata = '0;
        ld_dly = 1;
        repeat (4) @(negedge clk);
        issue(OP_HD, 2'd1);
        wait_idle(n);
        chk("R5 dn complete", {24'b0, obs(), timeout_err}, {24'b0, OFF, 1'b0});

        // R8: requests during a running power-up are ignored
        md_dly = 10; ld_dly = 10;
        issue(OP_HU, 2'd1);
        repeat (3) @(negedge clk);
        chk("R8 busy flag", {31'b0, status[3]}, 32'd1);
        dn_req = 1'b1; sw_wr = 1'b1; sw_wdata = 32'h1 << 9;
        @(negedge clk);
        dn_req = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
        wait_idle(n);
        chk("R8 ignore while busy", {25'b0, obs()}, {25'b0, ON});

        // R12: simultaneous requests from off, power-up takes precedence
        md_dly = 1; ld_dly = 1;
        issue(OP_HD, 2'd1);
        wait_idle(n);
        chk("R4 off before R12", {25'b0, obs()}, {25'b0, OFF});
        @(negedge clk);
        up_req = 1'b1; dn_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0; dn_req = 1'b0;
        wait_idle(n);
        chk("R12 up wins", {25'b0, obs()}, {25'b0, ON});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule